// File: doc/BRIEF.md
# Serial Configuration Chain Transfer Controller

This block lets a processor read and rewrite the configuration of a cell array whose cells are strung on one long serial chain. Each cell carries 64 configuration bits plus a separate set of hold flops, so the chain can be shifted without disturbing the array's running behaviour. Software reaches the controller through a 32-bit Wishbone slave port. It loads a 64-bit data register and a cell count, then writes a trigger. The controller drives a serial clock and data line to turn the chain through its data register by whole cells. The data register then holds the content of the cell that has arrived at the access point, and software can read or replace it there.

A second trigger, finish, keeps shifting until the chain is back in its run position. It then flips the hold strobe, and the cells adopt the freshly loaded bits. Both triggers clear themselves. The trigger register reads back a 1 for each operation still running, so software polls it for completion. A read of the count register returns the current chain offset rather than the value written.

The bus side is a plain request/acknowledge handshake with no back-pressure of its own. A request is held until the single-cycle acknowledge, and a second access can be taken no earlier than the clock after it.

Top module: `scx_xfer_ctrl`

## Requirements
- R1: Registers are decoded on address bits [7:2]. Word 0 is data bits 31:0, word 1 is data bits 63:32, word 2 is the cell count, and word 3 is the trigger register (bit 0 shift, bit 1 finish). Each byte of a written register changes only when its byte-select bit is high.
- R2: An access is acknowledged only when address bits [31:8] equal the base address. The acknowledge is one clock long, comes in the clock after cyc and stb are seen high, and is never high on two consecutive clocks.
- R3: A shift trigger moves the loop by (cell count) cells. The loop is the data register followed by the chain. The data register's MSB leaves first on ser_out, and the ser_in bit enters its LSB. One cell step moves the data register into chain cell 0, cell j into cell j+1, and the last cell into the data register. A count of zero does nothing.
- R4: ser_clk is low while idle. During a transfer it alternates every bus clock, with 64 rising edges per cell. ser_out is stable across every rising edge of ser_clk.
- R5: Reading word 2 returns the current offset in cells. The offset counts cell steps modulo (chain cells + 1) and is zero after reset.
- R6: A finish trigger shifts until the offset is zero, which takes zero cells if it is already zero. One clock after the last rising edge of ser_clk it toggles cell_hold. Nothing else changes cell_hold.
- R7: Trigger bits clear themselves. Reading word 3 returns bit 0 high while a shift runs and bit 1 high while a finish runs, and 0 when idle. A write with both bits set starts only the shift.
- R8: While a transfer runs, writes to the data, count and trigger registers are ignored.
- R9: Reset clears the data register, the count, the offset and any transfer, and drives cell_hold and ser_clk low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_sel | input | 4 | Byte selects |
| bus_adr | input | 32 | Byte address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Single-cycle acknowledge |
| ser_clk | output | 1 | Serial chain clock, half bus rate |
| ser_out | output | 1 | Serial data into the chain |
| ser_in | input | 1 | Serial data returning from the chain end |
| cell_hold | output | 1 | Hold strobe, toggled when a finish completes |

## Verification
The properties assume a bus master that holds cyc and stb until the acknowledge and lowers them in the clock after it. They also assume that ser_in comes from a chain that shifts on the rising edge of ser_clk, so it changes only after the controller has sampled it. The bench drives every request on falling clock edges, releases it on the acknowledge, and models the chain as a shift register clocked by ser_clk. With a three-cell chain it sweeps shift counts that wrap the four-slot loop, and it issues finishes from non-zero and zero offsets.

// File: rtl/scx_pkg.sv
package scx_pkg;
  localparam int CELL_BITS = 64;
  localparam int WORD_BITS = 32;
  localparam int WORDS     = CELL_BITS / WORD_BITS;

  typedef enum logic [5:0] {
    REG_DLO  = 6'd0,
    REG_DHI  = 6'd1,
    REG_CNT  = 6'd2,
    REG_TRIG = 6'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_SETTLE
  } eng_state_e;

  typedef struct packed {
    logic        wr;
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] dat;
  } reg_wr_t;

  function automatic logic [31:0] lane_merge(logic [31:0] cur, logic [31:0] nxt,
                                             logic [3:0] be);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[b*8 +: 8] = nxt[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/scx_bus_port.sv
module scx_bus_port
  import scx_pkg::*;
#(
  parameter logic [31:0] BASE_ADR = 32'h3000_0000,
  parameter int          CNT_W    = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc,
  input  logic                 stb,
  input  logic                 we,
  input  logic [3:0]           sel,
  input  logic [31:0]          adr,
  input  logic [31:0]          wdat,
  output logic [31:0]          rdat,
  output logic                 ack,
  output reg_wr_t              wr,
  input  logic [CELL_BITS-1:0] dreg,
  input  logic [CNT_W-1:0]     offset,
  input  logic                 busy_shift,
  input  logic                 busy_fin
);
  logic        hit, take;
  logic [5:0]  idx;
  logic [31:0] rd_mux;
  logic        unused_adr;

  assign unused_adr = ^adr[1:0];
  assign idx  = adr[7:2];
  assign hit  = cyc && stb && (adr[31:8] == BASE_ADR[31:8]);
  assign take = hit && !ack;

  assign wr.wr  = take && we;
  assign wr.idx = idx;
  assign wr.be  = sel;
  assign wr.dat = wdat;

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < WORDS; w++)
      if (idx == 6'(w)) rd_mux = dreg[w*WORD_BITS +: WORD_BITS];
    if (idx == REG_CNT)  rd_mux = 32'(offset);
    if (idx == REG_TRIG) rd_mux = {30'b0, busy_fin, busy_shift};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ack  <= 1'b0;
      rdat <= '0;
    end else begin
      ack <= take;
      if (take) rdat <= rd_mux;
    end
  end
endmodule

// File: rtl/scx_seq.sv
module scx_seq
  import scx_pkg::*;
#(
  parameter int LOOP_SLOTS = 1501,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_wr_t          wr,
  output logic             launch,
  output logic             capture,
  output logic             busy,
  output logic             busy_shift,
  output logic             busy_fin,
  output logic [CNT_W-1:0] offset,
  output logic             sclk,
  output logic             hold
);
  localparam int              PH_W      = $clog2(2 * CELL_BITS);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(2 * CELL_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(LOOP_SLOTS - 1);

  eng_state_e       st;
  logic             op_fin;
  logic [PH_W-1:0]  ph_ctr;
  logic [CNT_W-1:0] shift_cnt, left;
  logic [CNT_W-1:0] off_nx;
  logic             trig_wr, cnt_wr, cell_end;
  logic [31:0]      cnt_merged;

  assign trig_wr    = wr.wr && (wr.idx == REG_TRIG) && wr.be[0];
  assign cnt_wr     = wr.wr && (wr.idx == REG_CNT);
  assign cnt_merged = lane_merge(32'(shift_cnt), wr.dat, wr.be);

  assign launch     = (st == ST_RUN) && !ph_ctr[0];
  assign capture    = (st == ST_RUN) &&  ph_ctr[0];
  assign cell_end   = capture && (ph_ctr == PH_LAST);
  assign off_nx     = (offset == LAST_SLOT) ? '0 : offset + 1'b1;

  assign busy       = (st != ST_IDLE);
  assign busy_shift = busy && !op_fin;
  assign busy_fin   = busy &&  op_fin;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_fin    <= 1'b0;
      ph_ctr    <= '0;
      shift_cnt <= '0;
      left      <= '0;
      offset    <= '0;
      sclk      <= 1'b0;
      hold      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (cnt_wr) shift_cnt <= cnt_merged[CNT_W-1:0];
          if (trig_wr && wr.dat[0]) begin
            if (shift_cnt != '0) begin
              st     <= ST_RUN;
              op_fin <= 1'b0;
              left   <= shift_cnt;
              ph_ctr <= '0;
            end
          end else if (trig_wr && wr.dat[1]) begin
            op_fin <= 1'b1;
            ph_ctr <= '0;
            st     <= (offset != '0) ? ST_RUN : ST_SETTLE;
          end
        end
        ST_RUN: begin
          sclk   <= capture;
          ph_ctr <= cell_end ? '0 : ph_ctr + 1'b1;
          if (cell_end) begin
            offset <= off_nx;
            left   <= left - 1'b1;
            if (op_fin ? (off_nx == '0) : (left == CNT_W'(1)))
              st <= ST_SETTLE;
          end
        end
        default: begin
          sclk <= 1'b0;
          if (op_fin) hold <= !hold;
          st <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/scx_shifter.sv
module scx_shifter
  import scx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  reg_wr_t              wr,
  input  logic                 busy,
  input  logic                 launch,
  input  logic                 capture,
  input  logic                 sdi,
  output logic                 sdo,
  output logic [CELL_BITS-1:0] dreg
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dreg <= '0;
      sdo  <= 1'b0;
    end else begin
      if (launch) sdo <= dreg[CELL_BITS-1];
      if (capture) begin
        dreg <= {dreg[CELL_BITS-2:0], sdi};
      end else if (wr.wr && !busy) begin
        for (int w = 0; w < WORDS; w++)
          if (wr.idx == 6'(w))
            dreg[w*WORD_BITS +: WORD_BITS] <=
              lane_merge(dreg[w*WORD_BITS +: WORD_BITS], wr.dat, wr.be);
      end
    end
  end
endmodule

// File: rtl/scx_xfer_ctrl.sv
module scx_xfer_ctrl
  import scx_pkg::*;
#(
  parameter int          CHAIN_CELLS = 1500,
  parameter logic [31:0] BASE_ADR    = 32'h3000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_cyc,
  input  logic        bus_stb,
  input  logic        bus_we,
  input  logic [3:0]  bus_sel,
  input  logic [31:0] bus_adr,
  input  logic [31:0] bus_wdat,
  output logic [31:0] bus_rdat,
  output logic        bus_ack,
  output logic        ser_clk,
  output logic        ser_out,
  input  logic        ser_in,
  output logic        cell_hold
);
  localparam int LOOP_SLOTS = CHAIN_CELLS + 1;
  localparam int CNT_W      = $clog2(LOOP_SLOTS);

  reg_wr_t              wr;
  logic                 launch, capture, busy, busy_shift, busy_fin;
  logic [CNT_W-1:0]     cur_offset;
  logic [CELL_BITS-1:0] dreg;

  scx_bus_port #(.BASE_ADR(BASE_ADR), .CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst(rst), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
    .sel(bus_sel), .adr(bus_adr), .wdat(bus_wdat), .rdat(bus_rdat),
    .ack(bus_ack), .wr(wr), .dreg(dreg), .offset(cur_offset),
    .busy_shift(busy_shift), .busy_fin(busy_fin)
  );

  scx_seq #(.LOOP_SLOTS(LOOP_SLOTS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .wr(wr), .launch(launch), .capture(capture),
    .busy(busy), .busy_shift(busy_shift), .busy_fin(busy_fin),
    .offset(cur_offset), .sclk(ser_clk), .hold(cell_hold)
  );

  scx_shifter u_shf (
    .clk(clk), .rst(rst), .wr(wr), .busy(busy), .launch(launch),
    .capture(capture), .sdi(ser_in), .sdo(ser_out), .dreg(dreg)
  );
endmodule

// File: rtl/scx_xfer_chk.sv
module scx_xfer_chk #(
  parameter logic [31:0] BASE_ADR   = 32'h3000_0000,
  parameter int          LOOP_SLOTS = 1501,
  parameter int          CNT_W      = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_cyc,
  input logic             bus_stb,
  input logic [23:0]      adr_hi,
  input logic             bus_ack,
  input logic             ser_clk,
  input logic             ser_out,
  input logic             cell_hold,
  input logic             busy,
  input logic [CNT_W-1:0] cur_offset
);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R2
  ack_base_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_stb && adr_hi != BASE_ADR[31:8]) |=> !bus_ack);

  // R4
  sdo_steady_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_out));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !ser_clk);

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cell_hold) |-> !ser_clk);

  // R5
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(cur_offset) < LOOP_SLOTS);
endmodule

bind scx_xfer_ctrl scx_xfer_chk #(
  .BASE_ADR(BASE_ADR), .LOOP_SLOTS(LOOP_SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
  .adr_hi(bus_adr[31:8]), .bus_ack(bus_ack), .ser_clk(ser_clk),
  .ser_out(ser_out), .cell_hold(cell_hold), .busy(busy),
  .cur_offset(cur_offset)
);

// File: tb/scx_xfer_ctrl_test.sv
module scx_xfer_ctrl_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          NCELL      = 3;
  localparam int          NS         = NCELL + 1;
  localparam int          CB         = 64;
  localparam logic [31:0] BASE       = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, bwe = 1'b0;
  logic [3:0]  bsel = '0;
  logic [31:0] badr = '0, bwd = '0;
  logic [31:0] rdat;
  logic        ack, ser_clk, ser_out, ser_in, cell_hold;

  logic [NCELL*CB-1:0] chain;
  logic [NCELL*CB-1:0] img;
  logic [CB-1:0]       exp_s [NS];
  int                  rises = 0;
  int                  checks = 0, errors = 0;
  int                  acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scx_xfer_ctrl #(.CHAIN_CELLS(NCELL), .BASE_ADR(BASE)) uut (
    .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(bwe),
    .bus_sel(bsel), .bus_adr(badr), .bus_wdat(bwd), .bus_rdat(rdat),
    .bus_ack(ack), .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in),
    .cell_hold(cell_hold)
  );

  // behavioural chain: bit enters at 0, leaves at the top
  assign ser_in = chain[NCELL*CB-1];
  always @(posedge ser_clk) begin
    chain <= {chain[NCELL*CB-2:0], ser_out};
    rises <= rises + 1;
  end
  always @(cell_hold) img = chain;

  function automatic logic [CB-1:0] pat(int j);
    return {32'hC0DE_0000 + 32'(j), ~(32'h0101_0101 * 32'(j + 1))};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [31:0] adr, input logic [3:0] sel,
                     input logic [31:0] wd, output logic [31:0] rd);
    int n;
    n = 0;
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; bwe = we; badr = adr; bsel = sel; bwd = wd;
    do begin @(negedge clk); n++; end while (!ack && n < 20);
    rd = rdat;
    chk("R2 acknowledge seen", 64'(ack), 64'd1);
    cyc = 1'b0; stb = 1'b0; bwe = 1'b0;
    @(negedge clk);
    chk("R2 acknowledge lasts one clock", 64'(ack), 64'd0);
  endtask

  task automatic wr32(input int word, input logic [3:0] sel, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, BASE + 32'(word * 4), sel, d, dummy);
  endtask

  task automatic rd32(input int word, output logic [31:0] d);
    bus(1'b0, BASE + 32'(word * 4), 4'hF, 32'h0, d);
  endtask

  task automatic rd_dreg(output logic [63:0] d);
    logic [31:0] lo, hi;
    rd32(0, lo);
    rd32(1, hi);
    d = {hi, lo};
  endtask

  task automatic wait_idle();
    logic [31:0] t;
    int n;
    n = 0;
    do begin rd32(3, t); n++; end while (t != 0 && n < 400);
    chk("R7 trigger clears when done", 64'(t), 64'd0);
  endtask

  task automatic rot(input int k);
    logic [CB-1:0] t;
    repeat (k) begin
      t = exp_s[NS-1];
      for (int i = NS - 1; i > 0; i--) exp_s[i] = exp_s[i-1];
      exp_s[0] = t;
    end
  endtask

  task automatic do_shift(input int k);
    logic [63:0] d;
    logic [31:0] c;
    int r0;
    wr32(2, 4'hF, 32'(k));
    r0 = rises;
    wr32(3, 4'h1, 32'h1);
    wait_idle();
    rot(k);
    acc = (acc + k) % NS;
    chk("R4 rising edges per shift", 64'(rises - r0), 64'(CB * k));
    rd_dreg(d);
    chk("R3 data register after shift", d, exp_s[0]);
    rd32(2, c);
    chk("R5 offset readback", 64'(c), 64'(acc));
  endtask

  task automatic do_finish();
    logic [31:0] c;
    logic h0;
    int r0, k;
    k = (NS - acc) % NS;
    h0 = cell_hold;
    r0 = rises;
    wr32(3, 4'h1, 32'h2);
    wait_idle();
    rot(k);
    acc = 0;
    chk("R6 finish rising edges", 64'(rises - r0), 64'(CB * k));
    chk("R6 hold toggled", 64'(cell_hold), 64'(!h0));
    rd32(2, c);
    chk("R6 offset zero after finish", 64'(c), 64'd0);
    for (int j = 0; j < NCELL; j++)
      chk("R6 held cell image", img[j*CB +: CB], exp_s[j+1]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] d;
    int seq [6];
    for (int j = 0; j < NCELL; j++) begin
      chain[j*CB +: CB] = pat(j);
      exp_s[j+1] = pat(j);
    end
    exp_s[0] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk("R9 hold low", 64'(cell_hold), 64'd0);
    chk("R9 ser_clk low", 64'(ser_clk), 64'd0);
    for (int w = 0; w < 4; w++) begin
      rd32(w, v);
      chk("R9 register reset value", 64'(v), 64'd0);
    end

    // R1 byte lanes
    wr32(0, 4'hF, 32'h1122_3344);
    wr32(0, 4'h5, 32'hAABB_CCDD);
    rd32(0, v);
    chk("R1 data low byte lanes", 64'(v), 64'h11BB_33DD);
    wr32(1, 4'hF, 32'hCAFE_F00D);
    wr32(1, 4'h2, 32'h0000_0000);
    rd32(1, v);
    chk("R1 data high byte lanes", 64'(v), 64'hCAFE_000D);
    exp_s[0] = 64'hCAFE_000D_11BB_33DD;

    // R2 foreign base address gets no acknowledge
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; bwe = 1'b1; badr = 32'h3000_1000; bsel = 4'hF; bwd = 32'h1;
    begin
      int seen;
      seen = 0;
      repeat (8) begin @(negedge clk); if (ack) seen++; end
      chk("R2 no acknowledge off base", 64'(seen), 64'd0);
    end
    cyc = 1'b0; stb = 1'b0; bwe = 1'b0;
    rd32(3, v);
    chk("R2 foreign write started nothing", 64'(v), 64'd0);

    // R3 R4 R5 sweep of counts, wrapping the loop
    seq = '{1, 2, 3, 0, 3, 2};
    foreach (seq[i]) do_shift(seq[i]);

    // R6 finish after a data replacement
    wr32(0, 4'hF, 32'h0BAD_BEEF);
    wr32(1, 4'hF, 32'h600D_F00D);
    exp_s[0] = 64'h600D_F00D_0BAD_BEEF;
    do_finish();
    // R6 finish from offset zero
    do_finish();

    // R7 R8 busy readback and ignored writes
    wr32(2, 4'hF, 32'd2);
    wr32(3, 4'h1, 32'h1);
    rd32(3, v);
    chk("R7 shift busy bit", 64'(v), 64'd1);
    wr32(3, 4'h1, 32'h1);
    wr32(0, 4'hF, 32'hFFFF_FFFF);
    wr32(2, 4'hF, 32'd1);
    wait_idle();
    rot(2);
    acc = 2;
    rd_dreg(d);
    chk("R8 data write ignored while busy", d, exp_s[0]);
    rd32(2, v);
    chk("R8 second trigger ignored", 64'(v), 64'd2);
    wr32(3, 4'h1, 32'h1);
    wait_idle();
    rot(2);
    acc = 0;
    rd32(2, v);
    chk("R8 count write ignored while busy", 64'(v), 64'd0);

    wr32(2, 4'hF, 32'd1);
    wr32(3, 4'h1, 32'h3);
    rd32(3, v);
    chk("R7 both bits start only shift", 64'(v), 64'd1);
    wait_idle();
    rot(1);
    acc = 1;
    wr32(3, 4'h1, 32'h2);
    rd32(3, v);
    chk("R7 finish busy bit", 64'(v), 64'd2);
    wait_idle();
    rot(NS - 1);
    acc = 0;
    for (int j = 0; j < NCELL; j++)
      chk("R6 held image after busy test", img[j*CB +: CB], exp_s[j+1]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule